// File: doc/BRIEF.md
# CAN Transmit Slot Scheduler

This block holds eight outgoing CAN message slots and decides which one is offered next to the CAN protocol engine. The host fills a slot with an identifier (standard or extended), a remote-frame flag, a length code and up to eight data bytes. It then marks the slot as requested. Whenever no slot is being offered or carried on the bus, the scheduler picks one pending slot. It presents that slot's message together with a request strobe and waits for the engine's grant. After the grant it waits for the engine's outcome: done, or lost arbitration/error.

Two selection policies are available and can be switched at any time; a switch applies to the next selection. In rotating mode the search begins at the slot after the one most recently sent. In fixed mode each slot carries a host-programmed priority. The host may abort any pending slot. An abort acts at once on a slot that has not been granted. On a granted slot it only takes effect if that transmission fails. Per-slot status shows pending, sent or aborted, and a one-cycle completion pulse is raised per slot.

Top module: `can_tx_sched`

## Requirements
- R1: After reset no slot is pending, sent or aborted, `txReq` is low and `doneIrq` is zero.
- R2: A bit set in `hostReqMask` for a non-pending slot makes it pending and clears its sent and aborted flags on the next edge. A slot load (`hostWrEn`) aimed at a pending slot is ignored, so the message stored before the request is the one offered.
- R3: A slot requested on clock edge N is offered (`txReq` high, `txSlot`, message fields) from edge N+1 when the scheduler is idle. The offer holds steady until grant or abort.
- R4: With `policyFixed`=0 the search runs upward from the slot after the last one sent, wrapping from 7 to 0. Before any slot has been sent, the search starts at slot 0.
- R5: With `policyFixed`=1 the pending slot with the largest 4-bit priority value wins, and equal values go to the lower slot index.
- R6: `engDone` while a slot is granted clears its pending flag, sets its sent flag, pulses `doneIrq[slot]` for one cycle, and returns the scheduler to idle.
- R7: `engLost` while a slot is granted leaves it pending and not sent. Selection runs again at the next idle cycle under the policy in force then.
- R8: An abort of a pending slot that is not granted clears pending and sets aborted on the next edge. If that slot is currently offered, the offer is withdrawn.
- R9: An abort of a granted slot, or one arriving in the same cycle as its grant, is held. A following `engLost` turns it into aborted. A following `engDone` reports sent and not aborted.
- R10: An abort of a slot that is not pending changes none of its flags.
- R11: `engDone` and `engLost` arriving while no slot is granted change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| policyFixed | input | 1 | 0 = rotating selection, 1 = programmed priority |
| hostWrEn | input | 1 | Load the slot addressed by hostWrSlot |
| hostWrSlot | input | 3 | Slot index for a load |
| hostWrId | input | 29 | Identifier (standard IDs in the low 11 bits) |
| hostWrExt | input | 1 | Extended identifier flag |
| hostWrRemote | input | 1 | Remote frame flag |
| hostWrDlc | input | 4 | Data length code |
| hostWrData | input | 64 | Eight data bytes |
| hostWrPrio | input | 4 | Slot priority for fixed mode |
| hostReqMask | input | 8 | Per-slot transmit request |
| hostAbortMask | input | 8 | Per-slot abort request |
| engGrant | input | 1 | Engine accepts the offered slot |
| engDone | input | 1 | Granted slot transmitted successfully |
| engLost | input | 1 | Granted slot lost arbitration or hit an error |
| txReq | output | 1 | A slot is being offered |
| txSlot | output | 3 | Index of the offered or granted slot |
| txId | output | 29 | Identifier of that slot |
| txExt | output | 1 | Extended flag of that slot |
| txRemote | output | 1 | Remote flag of that slot |
| txDlc | output | 4 | Length code of that slot |
| txData | output | 64 | Data of that slot |
| pendingOut | output | 8 | Per-slot pending flags |
| sentOut | output | 8 | Per-slot sent flags |
| abortedOut | output | 8 | Per-slot aborted flags |
| doneIrq | output | 8 | One-cycle completion pulse per slot |

## Verification
All status flags and `doneIrq` change on the same edge that samples the causing request, abort or engine event. They are therefore due one cycle after the stimulus is driven. A request reaches `txReq` one edge later than it reaches `pendingOut`, because selection samples the flags registered on the previous edge. The bench drives inputs on the falling edge. It advances a behavioural model of the flags, the idle/offer/busy phase and the last-sent slot on each rising edge, and compares every output on the following falling edge. Scenario checks read the flags on the falling edge directly after the edge that consumed their stimulus.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int unsigned TX_SLOTS = 8;
  localparam int unsigned SLOT_W   = $clog2(TX_SLOTS);
  localparam int unsigned ID_W     = 29;
  localparam int unsigned DLC_W    = 4;
  localparam int unsigned DATA_W   = 64;

  typedef logic [SLOT_W-1:0] slotIdx_t;

  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_OFFER = 2'd1,
    SCH_BUSY  = 2'd2
  } schState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    slotIdx_t loadSlot;
    slotIdx_t curSlot;
  } dpStrobe_t;
endpackage

// File: rtl/can_tx_sched_pick.sv
module can_tx_sched_pick
  import can_tx_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input  logic [TX_SLOTS-1:0]        eligMask,
  input  logic [TX_SLOTS*PRIO_W-1:0] prioFlat,
  input  slotIdx_t                   lastSent,
  input  logic                       fixedMode,
  output logic                       found,
  output slotIdx_t                   pick
);
  logic [PRIO_W-1:0] prioArr [TX_SLOTS];

  for (genvar g = 0; g < TX_SLOTS; g++) begin : gUnpack
    assign prioArr[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  slotIdx_t          rrPick;
  slotIdx_t          fpPick;
  logic              rrFound;
  logic              fpFound;
  logic [PRIO_W-1:0] fpBest;

  // rotating search from the slot after the last one sent
  always_comb begin
    int unsigned idx;
    idx     = 0;
    rrFound = 1'b0;
    rrPick  = '0;
    for (int k = 1; k <= TX_SLOTS; k++) begin
      idx = (int'(lastSent) + k) % TX_SLOTS;
      if (!rrFound && eligMask[idx]) begin
        rrFound = 1'b1;
        rrPick  = slotIdx_t'(idx);
      end
    end
  end

  // largest value wins, strict compare keeps the lower index on ties
  always_comb begin
    fpFound = 1'b0;
    fpPick  = '0;
    fpBest  = '0;
    for (int i = 0; i < TX_SLOTS; i++) begin
      if (eligMask[i] && (!fpFound || prioArr[i] > fpBest)) begin
        fpFound = 1'b1;
        fpPick  = slotIdx_t'(i);
        fpBest  = prioArr[i];
      end
    end
  end

  assign found = fixedMode ? fpFound : rrFound;
  assign pick  = fixedMode ? fpPick : rrPick;
endmodule

// File: rtl/can_tx_sched_dp.sv
module can_tx_sched_dp
  import can_tx_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [ID_W-1:0]            wrId,
  input  logic                       wrExt,
  input  logic                       wrRemote,
  input  logic [DLC_W-1:0]           wrDlc,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [PRIO_W-1:0]          wrPrio,
  output logic [TX_SLOTS*PRIO_W-1:0] prioFlat,
  output logic [ID_W-1:0]            txId,
  output logic                       txExt,
  output logic                       txRemote,
  output logic [DLC_W-1:0]           txDlc,
  output logic [DATA_W-1:0]          txData
);
  logic [ID_W-1:0]   idMem   [TX_SLOTS];
  logic              extMem  [TX_SLOTS];
  logic              rmtMem  [TX_SLOTS];
  logic [DLC_W-1:0]  dlcMem  [TX_SLOTS];
  logic [DATA_W-1:0] dataMem [TX_SLOTS];
  logic [PRIO_W-1:0] prioMem [TX_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TX_SLOTS; i++) begin
        idMem[i]   <= '0;
        extMem[i]  <= 1'b0;
        rmtMem[i]  <= 1'b0;
        dlcMem[i]  <= '0;
        dataMem[i] <= '0;
        prioMem[i] <= '0;
      end
    end else if (strobe.load) begin
      idMem[strobe.loadSlot]   <= wrId;
      extMem[strobe.loadSlot]  <= wrExt;
      rmtMem[strobe.loadSlot]  <= wrRemote;
      dlcMem[strobe.loadSlot]  <= wrDlc;
      dataMem[strobe.loadSlot] <= wrData;
      prioMem[strobe.loadSlot] <= wrPrio;
    end
  end

  for (genvar g = 0; g < TX_SLOTS; g++) begin : gPack
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioMem[g];
  end

  assign txId     = idMem[strobe.curSlot];
  assign txExt    = extMem[strobe.curSlot];
  assign txRemote = rmtMem[strobe.curSlot];
  assign txDlc    = dlcMem[strobe.curSlot];
  assign txData   = dataMem[strobe.curSlot];
endmodule

// File: rtl/can_tx_sched_ctrl.sv
module can_tx_sched_ctrl
  import can_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  slotIdx_t            hostWrSlot,
  input  logic [TX_SLOTS-1:0] hostReqMask,
  input  logic [TX_SLOTS-1:0] hostAbortMask,
  input  logic                engGrant,
  input  logic                engDone,
  input  logic                engLost,
  input  logic                pickFound,
  input  slotIdx_t            pickSlot,
  output dpStrobe_t           strobe,
  output logic [TX_SLOTS-1:0] eligMask,
  output slotIdx_t            lastSent,
  output logic                txReq,
  output logic [TX_SLOTS-1:0] pendingOut,
  output logic [TX_SLOTS-1:0] sentOut,
  output logic [TX_SLOTS-1:0] abortedOut,
  output logic [TX_SLOTS-1:0] doneIrq
);
  schState_t           state;
  slotIdx_t            curSlot;
  logic                abortHeld;
  logic [TX_SLOTS-1:0] curOneHot;
  logic                grantNow;
  logic                doneNow;
  logic                lostNow;
  logic                abortCur;
  logic                dropCur;
  logic [TX_SLOTS-1:0] protectMask;
  logic [TX_SLOTS-1:0] immAbort;
  logic [TX_SLOTS-1:0] newReq;
  logic [TX_SLOTS-1:0] doneMask;
  logic [TX_SLOTS-1:0] dropMask;

  assign curOneHot   = {{(TX_SLOTS-1){1'b0}}, 1'b1} << curSlot;
  assign grantNow    = (state == SCH_OFFER) && engGrant;
  assign doneNow     = (state == SCH_BUSY) && engDone;
  assign lostNow     = (state == SCH_BUSY) && engLost && !engDone;
  assign abortCur    = hostAbortMask[curSlot];
  assign dropCur     = lostNow && (abortHeld || abortCur);
  assign protectMask = ((state == SCH_BUSY) || grantNow) ? curOneHot : '0;
  assign immAbort    = hostAbortMask & pendingOut & ~protectMask;
  assign newReq      = hostReqMask & ~pendingOut;
  assign doneMask    = doneNow ? curOneHot : '0;
  assign dropMask    = dropCur ? curOneHot : '0;
  assign eligMask    = pendingOut & ~hostAbortMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingOut <= '0;
      sentOut    <= '0;
      abortedOut <= '0;
      doneIrq    <= '0;
    end else begin
      pendingOut <= (pendingOut & ~immAbort & ~doneMask & ~dropMask) | newReq;
      sentOut    <= (sentOut & ~newReq) | doneMask;
      abortedOut <= (abortedOut & ~newReq) | immAbort | dropMask;
      doneIrq    <= doneMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SCH_IDLE;
      curSlot   <= '0;
      lastSent  <= slotIdx_t'(TX_SLOTS - 1);
      abortHeld <= 1'b0;
    end else begin
      unique case (state)
        SCH_IDLE: begin
          if (pickFound) begin
            curSlot <= pickSlot;
            state   <= SCH_OFFER;
          end
        end
        SCH_OFFER: begin
          if (engGrant) begin
            state     <= SCH_BUSY;
            abortHeld <= abortCur;
          end else if (abortCur) begin
            state <= SCH_IDLE;
          end
        end
        SCH_BUSY: begin
          if (doneNow) begin
            lastSent  <= curSlot;
            state     <= SCH_IDLE;
            abortHeld <= 1'b0;
          end else if (lostNow) begin
            state     <= SCH_IDLE;
            abortHeld <= 1'b0;
          end else if (abortCur) begin
            abortHeld <= 1'b1;
          end
        end
        default: state <= SCH_IDLE;
      endcase
    end
  end

  assign txReq           = (state == SCH_OFFER);
  assign strobe.load     = hostWrEn && !pendingOut[hostWrSlot];
  assign strobe.loadSlot = hostWrSlot;
  assign strobe.curSlot  = curSlot;
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_tx_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                policyFixed,
  input  logic                hostWrEn,
  input  logic [SLOT_W-1:0]   hostWrSlot,
  input  logic [ID_W-1:0]     hostWrId,
  input  logic                hostWrExt,
  input  logic                hostWrRemote,
  input  logic [DLC_W-1:0]    hostWrDlc,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic [PRIO_W-1:0]   hostWrPrio,
  input  logic [TX_SLOTS-1:0] hostReqMask,
  input  logic [TX_SLOTS-1:0] hostAbortMask,
  input  logic                engGrant,
  input  logic                engDone,
  input  logic                engLost,
  output logic                txReq,
  output logic [SLOT_W-1:0]   txSlot,
  output logic [ID_W-1:0]     txId,
  output logic                txExt,
  output logic                txRemote,
  output logic [DLC_W-1:0]    txDlc,
  output logic [DATA_W-1:0]   txData,
  output logic [TX_SLOTS-1:0] pendingOut,
  output logic [TX_SLOTS-1:0] sentOut,
  output logic [TX_SLOTS-1:0] abortedOut,
  output logic [TX_SLOTS-1:0] doneIrq
);
  dpStrobe_t                  strobe;
  logic [TX_SLOTS-1:0]        eligMask;
  logic [TX_SLOTS*PRIO_W-1:0] prioFlat;
  slotIdx_t                   lastSent;
  logic                       pickFound;
  slotIdx_t                   pickSlot;

  can_tx_sched_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostWrEn     (hostWrEn),
    .hostWrSlot   (hostWrSlot),
    .hostReqMask  (hostReqMask),
    .hostAbortMask(hostAbortMask),
    .engGrant     (engGrant),
    .engDone      (engDone),
    .engLost      (engLost),
    .pickFound    (pickFound),
    .pickSlot     (pickSlot),
    .strobe       (strobe),
    .eligMask     (eligMask),
    .lastSent     (lastSent),
    .txReq        (txReq),
    .pendingOut   (pendingOut),
    .sentOut      (sentOut),
    .abortedOut   (abortedOut),
    .doneIrq      (doneIrq)
  );

  can_tx_sched_pick #(.PRIO_W(PRIO_W)) u_pick (
    .eligMask (eligMask),
    .prioFlat (prioFlat),
    .lastSent (lastSent),
    .fixedMode(policyFixed),
    .found    (pickFound),
    .pick     (pickSlot)
  );

  can_tx_sched_dp #(.PRIO_W(PRIO_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrId    (hostWrId),
    .wrExt   (hostWrExt),
    .wrRemote(hostWrRemote),
    .wrDlc   (hostWrDlc),
    .wrData  (hostWrData),
    .wrPrio  (hostWrPrio),
    .prioFlat(prioFlat),
    .txId    (txId),
    .txExt   (txExt),
    .txRemote(txRemote),
    .txDlc   (txDlc),
    .txData  (txData)
  );

  assign txSlot = strobe.curSlot;
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk
  import can_tx_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                policyFixed,
  input logic                hostWrEn,
  input logic [SLOT_W-1:0]   hostWrSlot,
  input logic [ID_W-1:0]     hostWrId,
  input logic                hostWrExt,
  input logic                hostWrRemote,
  input logic [DLC_W-1:0]    hostWrDlc,
  input logic [DATA_W-1:0]   hostWrData,
  input logic [PRIO_W-1:0]   hostWrPrio,
  input logic [TX_SLOTS-1:0] hostReqMask,
  input logic [TX_SLOTS-1:0] hostAbortMask,
  input logic                engGrant,
  input logic                engDone,
  input logic                engLost,
  input logic                txReq,
  input logic [SLOT_W-1:0]   txSlot,
  input logic [ID_W-1:0]     txId,
  input logic                txExt,
  input logic                txRemote,
  input logic [DLC_W-1:0]    txDlc,
  input logic [DATA_W-1:0]   txData,
  input logic [TX_SLOTS-1:0] pendingOut,
  input logic [TX_SLOTS-1:0] sentOut,
  input logic [TX_SLOTS-1:0] abortedOut,
  input logic [TX_SLOTS-1:0] doneIrq
);
  // R3
  offer_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> pendingOut[txSlot]);

  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !engGrant && !hostAbortMask[txSlot]) |=> (txReq && $stable(txSlot)));

  // R6
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneIrq));

  // R6
  irq_sent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|doneIrq) |-> ((doneIrq & sentOut & ~pendingOut) == doneIrq));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|doneIrq) |-> $past(engDone));

  // R8
  abort_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortedOut & pendingOut) == '0);

  // R9
  sent_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sentOut & abortedOut) == '0);
endmodule

bind can_tx_sched can_tx_sched_chk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/can_tx_sched_bench.sv
module can_tx_sched_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        policyFixed;
  logic        hostWrEn;
  logic [2:0]  hostWrSlot;
  logic [28:0] hostWrId;
  logic        hostWrExt;
  logic        hostWrRemote;
  logic [3:0]  hostWrDlc;
  logic [63:0] hostWrData;
  logic [3:0]  hostWrPrio;
  logic [7:0]  hostReqMask;
  logic [7:0]  hostAbortMask;
  logic        engGrant;
  logic        engDone;
  logic        engLost;
  logic        txReq;
  logic [2:0]  txSlot;
  logic [28:0] txId;
  logic        txExt;
  logic        txRemote;
  logic [3:0]  txDlc;
  logic [63:0] txData;
  logic [7:0]  pendingOut;
  logic [7:0]  sentOut;
  logic [7:0]  abortedOut;
  logic [7:0]  doneIrq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  can_tx_sched u_can_tx_sched (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int          mSt;      // 0 idle, 1 offering, 2 on bus
  int          mCur;
  int          mLast;
  bit          mHeld;
  bit          mPend [8];
  bit          mSnt  [8];
  bit          mAbt  [8];
  bit          mIrq  [8];
  logic [28:0] mId   [8];
  logic [63:0] mData [8];
  int          mPrio [8];

  function automatic logic [7:0] pack(bit a [8]);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = a[i];
    return v;
  endfunction

  always @(posedge clk) begin
    bit oldPend [8];
    int nst;
    int best;
    int bestPrio;
    if (!rstN) begin
      mSt = 0; mCur = 0; mLast = 7; mHeld = 0;
      for (int i = 0; i < 8; i++) begin
        mPend[i] = 0; mSnt[i] = 0; mAbt[i] = 0; mIrq[i] = 0;
        mId[i] = '0; mData[i] = '0; mPrio[i] = 0;
      end
    end else begin
      oldPend = mPend;
      nst = mSt;
      for (int i = 0; i < 8; i++) mIrq[i] = 0;
      if (mSt == 2) begin
        if (engDone) begin
          mSnt[mCur] = 1; mPend[mCur] = 0; mIrq[mCur] = 1;
          mLast = mCur; nst = 0; mHeld = 0;
        end else if (engLost) begin
          if (mHeld || hostAbortMask[mCur]) begin
            mPend[mCur] = 0; mAbt[mCur] = 1;
          end
          nst = 0; mHeld = 0;
        end else if (hostAbortMask[mCur]) mHeld = 1;
      end else if (mSt == 1) begin
        if (engGrant) begin
          nst = 2; mHeld = hostAbortMask[mCur];
        end else if (hostAbortMask[mCur]) nst = 0;
      end
      for (int i = 0; i < 8; i++)
        if (hostAbortMask[i] && oldPend[i] &&
            !((mSt == 2 || (mSt == 1 && engGrant)) && i == mCur)) begin
          mPend[i] = 0; mAbt[i] = 1;
        end
      for (int i = 0; i < 8; i++)
        if (hostReqMask[i] && !oldPend[i]) begin
          mPend[i] = 1; mSnt[i] = 0; mAbt[i] = 0;
        end
      if (mSt == 0) begin
        best = -1; bestPrio = -1;
        if (policyFixed) begin
          for (int i = 0; i < 8; i++)
            if (oldPend[i] && !hostAbortMask[i] && mPrio[i] > bestPrio) begin
              best = i; bestPrio = mPrio[i];
            end
        end else begin
          for (int k = 1; k <= 8; k++) begin
            int j;
            j = (mLast + k) % 8;
            if (best < 0 && oldPend[j] && !hostAbortMask[j]) best = j;
          end
        end
        if (best >= 0) begin
          mCur = best; nst = 1;
        end
      end
      if (hostWrEn && !oldPend[hostWrSlot]) begin
        mId[hostWrSlot]   = hostWrId;
        mData[hostWrSlot] = hostWrData;
        mPrio[hostWrSlot] = int'(hostWrPrio);
      end
      mSt = nst;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R3 txReq", 64'(txReq), 64'(mSt == 1));
      if (mSt == 1) begin
        check("R4 txSlot", 64'(txSlot), 64'(mCur));
        check("R2 txId", 64'(txId), 64'(mId[mCur]));
        check("R2 txData", txData, mData[mCur]);
      end
      check("R2 pendingOut", 64'(pendingOut), 64'(pack(mPend)));
      check("R6 sentOut", 64'(sentOut), 64'(pack(mSnt)));
      check("R8 abortedOut", 64'(abortedOut), 64'(pack(mAbt)));
      check("R6 doneIrq", 64'(doneIrq), 64'(pack(mIrq)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      report();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [3:0] prioOf(int s);
    case (s)
      1: return 4'd2;
      2: return 4'd5;
      3: return 4'd9;
      4: return 4'd9;
      6: return 4'd12;
      default: return 4'd0;
    endcase
  endfunction

  task automatic hostLoad(int s, logic [28:0] id);
    hostWrEn   = 1'b1;
    hostWrSlot = 3'(s);
    hostWrId   = id;
    hostWrExt  = id[11];
    hostWrRemote = 1'b0;
    hostWrDlc  = 4'd8;
    hostWrData = {8{8'(s + 8'h30)}};
    hostWrPrio = prioOf(s);
    cyc();
    hostWrEn = 1'b0;
  endtask

  task automatic request(logic [7:0] m);
    hostReqMask = m;
    cyc();
    hostReqMask = '0;
  endtask

  task automatic waitOffer();
    int n = 0;
    while (!txReq && n < 40) begin
      cyc();
      n++;
    end
  endtask

  task automatic serve(int exp, bit lost, logic [7:0] abortMid, string req);
    waitOffer();
    check(req, 64'(txSlot), 64'(exp));
    engGrant = 1'b1;
    cyc();
    engGrant = 1'b0;
    hostAbortMask = abortMid;
    cyc();
    hostAbortMask = '0;
    cyc();
    if (lost) engLost = 1'b1; else engDone = 1'b1;
    cyc();
    engLost = 1'b0;
    engDone = 1'b0;
  endtask

  initial begin
    logic [7:0] snap;
    rstN = 1'b0; policyFixed = 1'b0; hostWrEn = 1'b0; hostWrSlot = '0;
    hostWrId = '0; hostWrExt = 1'b0; hostWrRemote = 1'b0; hostWrDlc = '0;
    hostWrData = '0; hostWrPrio = '0; hostReqMask = '0; hostAbortMask = '0;
    engGrant = 1'b0; engDone = 1'b0; engLost = 1'b0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1
    check("R1 pending", 64'(pendingOut), 64'h0);
    check("R1 sent", 64'(sentOut), 64'h0);
    check("R1 aborted", 64'(abortedOut), 64'h0);
    check("R1 txReq", 64'(txReq), 64'h0);
    check("R1 irq", 64'(doneIrq), 64'h0);

    for (int s = 0; s < 8; s++) hostLoad(s, 29'h100 + 29'(s));

    // R4 rotating order from slot 0
    request(8'b0010_0110);
    serve(1, 0, '0, "R4 first");
    serve(2, 0, '0, "R4 next");
    serve(5, 0, '0, "R4 next");
    request(8'b0100_0001);
    serve(6, 0, '0, "R4 after last");
    serve(0, 0, '0, "R4 wrap");

    // R5 fixed priority, tie between 3 and 4
    policyFixed = 1'b1;
    request(8'b0101_1010);
    serve(6, 0, '0, "R5 highest");
    serve(3, 0, '0, "R5 tie low index");
    serve(4, 0, '0, "R5 tie second");
    serve(1, 0, '0, "R5 lowest");

    // R7 lost arbitration then policy switch
    policyFixed = 1'b0;
    request(8'b0000_1100);
    serve(2, 1, '0, "R7 offered");
    check("R7 still pending", 64'(pendingOut[2]), 64'h1);
    check("R7 not sent", 64'(sentOut[2]), 64'h0);
    policyFixed = 1'b1;
    serve(3, 0, '0, "R7 reselect");
    serve(2, 0, '0, "R7 retry");
    policyFixed = 1'b0;

    // R8 abort before grant, offer withdrawn
    request(8'b1011_0000);
    waitOffer();
    check("R8 offered", 64'(txSlot), 64'd4);
    hostAbortMask = 8'h10;
    cyc();
    hostAbortMask = '0;
    check("R8 withdrawn", 64'(txReq), 64'h0);
    check("R8 aborted", 64'(abortedOut[4]), 64'h1);
    check("R8 cleared", 64'(pendingOut[4]), 64'h0);
    serve(5, 0, 8'h80, "R8 next");
    check("R8 waiting slot aborted", 64'(abortedOut[7]), 64'h1);
    check("R8 sent", 64'(sentOut[5]), 64'h1);

    // R9 abort while on the bus
    request(8'h01);
    serve(0, 0, 8'h01, "R9 done wins");
    check("R9 sent", 64'(sentOut[0]), 64'h1);
    check("R9 not aborted", 64'(abortedOut[0]), 64'h0);
    request(8'h02);
    serve(1, 1, 8'h02, "R9 lost");
    check("R9 aborted", 64'(abortedOut[1]), 64'h1);
    check("R9 cleared", 64'(pendingOut[1]), 64'h0);
    request(8'h04);
    waitOffer();
    engGrant = 1'b1;
    hostAbortMask = 8'h04;
    cyc();
    engGrant = 1'b0;
    hostAbortMask = '0;
    check("R9 same-cycle kept", 64'(pendingOut[2]), 64'h1);
    check("R9 same-cycle flag", 64'(abortedOut[2]), 64'h0);
    engLost = 1'b1;
    cyc();
    engLost = 1'b0;
    check("R9 same-cycle aborted", 64'(abortedOut[2]), 64'h1);

    // R10 abort of a slot that is not pending
    hostAbortMask = 8'h40;
    cyc();
    hostAbortMask = '0;
    check("R10 aborted", 64'(abortedOut[6]), 64'h0);
    check("R10 sent", 64'(sentOut[6]), 64'h1);

    // R11 stray engine events
    snap = sentOut;
    engDone = 1'b1;
    engLost = 1'b1;
    cyc();
    engDone = 1'b0;
    engLost = 1'b0;
    check("R11 sent", 64'(sentOut), 64'(snap));
    check("R11 irq", 64'(doneIrq), 64'h0);

    // R2 load ignored while pending, request clears sent, R3 latency
    request(8'h08);
    waitOffer();
    engGrant = 1'b1;
    cyc();
    engGrant = 1'b0;
    hostLoad(3, 29'h1ABC);
    engDone = 1'b1;
    cyc();
    engDone = 1'b0;
    request(8'h08);
    check("R2 pending", 64'(pendingOut[3]), 64'h1);
    check("R2 sent cleared", 64'(sentOut[3]), 64'h0);
    cyc();
    check("R3 latency", 64'(txReq), 64'h1);
    check("R2 old id kept", 64'(txId), 64'h103);
    serve(3, 0, '0, "R2 resend");

    repeat (3) cyc();
    report();
  end
endmodule